// File: doc/BRIEF.md
# Strap capture and frequency-select override

This block sits between the shared strap pads of a clock generator and its synthesis core. While power-on reset is held, it keeps sampling the four frequency-select straps and the operating-mode strap on every clock edge. Once reset is released it freezes that sample and reports that the shared pads may now be driven as clock outputs. After that point, nothing on the pads can change the stored straps.

The 4-bit frequency code for the synthesizer comes from one of two places. One is the frozen strap value. The other is a software code held in the control byte, and a bit in the same byte picks between them. From the selected code the block derives a one-bit PCI divider choice: divide the CPU clock by 2 or by 3.

The block also turns the configuration bytes into gate enables for each clock output, a global tristate control and spread-spectrum controls. It builds the readback values for the bytes that carry strap information. Depending on the mode strap, it sets what one pin does: a reference clock output, or the PCI stop input.

Top module: `clk_strap_ctl`

## Requirements
- R1: While rst_ni is low, the straps (fs_pad_i and mode_pad_i) are captured at every rising clock edge, up to and including the first edge after release. After that they hold their value whatever the pads do. straps_out_o is 0 during reset and becomes 1 from the first rising edge after release.
- R2: When ctl_i[3] = 0, freq_code_o equals the captured fs straps, with bit 3 = FS3 and bit 0 = FS0. When ctl_i[3] = 1, freq_code_o = {ctl_i[2], ctl_i[6], ctl_i[5], ctl_i[4]}.
- R3: ss_en_o equals ctl_i[1]. ss_down_o equals ctl_i[7] when ctl_i[1] = 1 and is forced to 0 when ctl_i[1] = 0 (1 = down spread, 0 = centre spread).
- R4: tristate_o equals ctl_i[0]. While it is 1, every bit of cpu_gate_o, sdram_gate_o, pci_gate_o and fix_gate_o is 0.
- R5: With tristate off, each gate bit equals its enable bit (1 = run, 0 = held low), as follows:
  - cpu_gate_o = {en_cpu_i[6], en_cpu_i[2:0]}
  - sdram_gate_o = {en_cpu_i[3], en_sdram_i[7:0], en_periph_i[7:4]}
  - pci_gate_o = {en_pci_i[6], en_pci_i[4:0]}
  - fix_gate_o = {en_periph_i[3], en_periph_i[2], en_periph_i[1], en_periph_i[0] & mode}
- R6: Readback places the captured straps inverted: ~FS2 in rb_cpu_o[7], ~FS0 in rb_pci_o[7], ~FS1 in rb_rsvd_o[3] and ~FS3 in rb_rsvd_o[1]. The other non-reserved bits echo the written bytes.
- R7: Reserved bits read back as 1 and have no effect on any output, whatever value is written to them. These are en_cpu_i[5:4], en_cpu_i[7], en_pci_i[5] and en_pci_i[7], and all rb_rsvd_o bits other than 3 and 1.
- R8: After release, a captured mode strap of 1 sets pin2_ref_o = 1 and pci_stop_in_o = 0. A mode strap of 0 sets pin2_ref_o = 0 and pci_stop_in_o = 1, and also forces fix_gate_o[0] to 0. Both are 0 during reset.
- R9: pci_div3_o is 1 for codes 0-4 and 8-12 and 0 for codes 5-7 and 13-15. Examples: code 0 pairs 124 MHz with 41.33 MHz, code 8 pairs 100 MHz with 33.33 MHz, and code 15 pairs 60 MHz with 30 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low power-on reset |
| fs_pad_i | input | 4 | Frequency strap pad levels |
| mode_pad_i | input | 1 | Mode strap pad level |
| ctl_i | input | 8 | Control byte: source select, code, spread, tristate |
| en_cpu_i | input | 8 | CPU-group enable byte |
| en_pci_i | input | 8 | PCI-group enable byte |
| en_sdram_i | input | 8 | Upper SDRAM enable byte |
| en_periph_i | input | 8 | Lower SDRAM and fixed-clock enable byte |
| straps_out_o | output | 1 | Strap pads switched to output use |
| pin2_ref_o | output | 1 | Pin 2 drives the reference clock |
| pci_stop_in_o | output | 1 | Pin 2 is the PCI stop input |
| freq_code_o | output | 4 | Selected frequency code |
| pci_div3_o | output | 1 | 1 = PCI is CPU/3, 0 = CPU/2 |
| ss_en_o | output | 1 | Spread spectrum enabled |
| ss_down_o | output | 1 | Down spread selected |
| tristate_o | output | 1 | Float all clock outputs |
| cpu_gate_o | output | 4 | CPU clock gates {free, 2, 1, 0} |
| sdram_gate_o | output | 13 | SDRAM gates {free, 11..0} |
| pci_gate_o | output | 6 | PCI gates {free, 4..0} |
| fix_gate_o | output | 4 | Fixed-clock gates {48M, 24M, ref1, ref0} |
| rb_cpu_o | output | 8 | CPU-byte readback |
| rb_pci_o | output | 8 | PCI-byte readback |
| rb_rsvd_o | output | 8 | Reserved-byte readback |

## Verification
The bench builds the block with its default four-bit frequency code and the default divide map. With that build, all 32 strap patterns can be applied through a reset cycle each, together with all 256 control-byte values. A walking zero across every bit of the four enable bytes then reaches each gate and each reserved bit. The divide bit is checked against a frequency table kept in the bench, with the ratio worked out arithmetically from the CPU and PCI rates.

// File: rtl/clk_strap_pkg.sv
package clk_strap_pkg;
  localparam int unsigned CPU_N = 4;
  localparam int unsigned SDR_N = 13;
  localparam int unsigned PCI_N = 6;
  localparam int unsigned FIX_N = 4;

  function automatic logic div3_of(input logic [15:0] map, input logic [3:0] code);
    return map[code];
  endfunction
endpackage

// File: rtl/strap_capture.sv
module strap_capture #(
  parameter int unsigned W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pad_i,
  output logic [W-1:0] strap_o,
  output logic         released_o
);
  logic         released_q;
  logic [W-1:0] strap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) released_q <= 1'b0;
    else         released_q <= 1'b1;
  end

  // keep sampling until the release flag is seen
  always_ff @(posedge clk_i) begin
    if (!released_q) strap_q <= pad_i;
  end

  assign strap_o    = strap_q;
  assign released_o = released_q;

  a_r1_strap_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    released_q |=> $stable(strap_q));
  a_r1_release_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    released_q |=> released_q);
endmodule

// File: rtl/freq_select.sv
module freq_select #(
  parameter int unsigned  FS_W     = 4,
  parameter logic [15:0]  DIV3_MAP = 16'h1F1F
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [FS_W-1:0] strap_fs_i,
  input  logic [7:0]      ctl_i,
  output logic [FS_W-1:0] code_o,
  output logic            div3_o,
  output logic            ss_en_o,
  output logic            ss_down_o
);
  import clk_strap_pkg::*;

  logic            use_sw;
  logic [FS_W-1:0] sw_code;

  assign use_sw  = ctl_i[3];
  assign sw_code = {ctl_i[2], ctl_i[6:4]};
  assign code_o  = use_sw ? sw_code : strap_fs_i;
  assign div3_o  = div3_of(DIV3_MAP, code_o);

  // down/centre choice is only legal while spreading
  assign ss_en_o   = ctl_i[1];
  assign ss_down_o = ctl_i[1] & ctl_i[7];

  a_r2_strap_path_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && $past(valid_i) && !use_sw && !$past(use_sw)) |-> $stable(code_o));
  a_r3_down_needs_spread: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_down_o |-> ss_en_o);
endmodule

// File: rtl/out_gate.sv
module out_gate
  import clk_strap_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tri_i,
  input  logic             mode_i,
  input  logic [7:0]       en_cpu_i,
  input  logic [7:0]       en_pci_i,
  input  logic [7:0]       en_sdram_i,
  input  logic [7:0]       en_periph_i,
  output logic [CPU_N-1:0] cpu_o,
  output logic [SDR_N-1:0] sdram_o,
  output logic [PCI_N-1:0] pci_o,
  output logic [FIX_N-1:0] fix_o
);
  logic [CPU_N-1:0] cpu_en;
  logic [SDR_N-1:0] sdr_en;
  logic [PCI_N-1:0] pci_en;
  logic [FIX_N-1:0] fix_en;

  assign cpu_en = {en_cpu_i[6], en_cpu_i[2:0]};
  assign sdr_en = {en_cpu_i[3], en_sdram_i, en_periph_i[7:4]};
  assign pci_en = {en_pci_i[6], en_pci_i[4:0]};
  // ref0 shares pin 2, which is an input in mobile mode
  assign fix_en = {en_periph_i[3:1], en_periph_i[0] & mode_i};

  assign cpu_o   = tri_i ? '0 : cpu_en;
  assign sdram_o = tri_i ? '0 : sdr_en;
  assign pci_o   = tri_i ? '0 : pci_en;
  assign fix_o   = tri_i ? '0 : fix_en;

  a_r4_tristate_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tri_i |-> (cpu_o == '0 && sdram_o == '0 && pci_o == '0 && fix_o == '0));
  a_r8_ref0_off_mobile: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i |-> !fix_o[0]);
endmodule

// File: rtl/clk_strap_ctl.sv
module clk_strap_ctl
  import clk_strap_pkg::*;
#(
  parameter int unsigned FS_W     = 4,
  parameter logic [15:0] DIV3_MAP = 16'h1F1F
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [FS_W-1:0]  fs_pad_i,
  input  logic             mode_pad_i,
  input  logic [7:0]       ctl_i,
  input  logic [7:0]       en_cpu_i,
  input  logic [7:0]       en_pci_i,
  input  logic [7:0]       en_sdram_i,
  input  logic [7:0]       en_periph_i,
  output logic             straps_out_o,
  output logic             pin2_ref_o,
  output logic             pci_stop_in_o,
  output logic [FS_W-1:0]  freq_code_o,
  output logic             pci_div3_o,
  output logic             ss_en_o,
  output logic             ss_down_o,
  output logic             tristate_o,
  output logic [CPU_N-1:0] cpu_gate_o,
  output logic [SDR_N-1:0] sdram_gate_o,
  output logic [PCI_N-1:0] pci_gate_o,
  output logic [FIX_N-1:0] fix_gate_o,
  output logic [7:0]       rb_cpu_o,
  output logic [7:0]       rb_pci_o,
  output logic [7:0]       rb_rsvd_o
);
  localparam int unsigned STRAP_W = FS_W + 1;

  logic [STRAP_W-1:0] strap;
  logic               released;
  logic [FS_W-1:0]    fs_q;
  logic               mode_q;

  strap_capture #(.W(STRAP_W)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pad_i      ({mode_pad_i, fs_pad_i}),
    .strap_o    (strap),
    .released_o (released)
  );

  assign fs_q   = strap[FS_W-1:0];
  assign mode_q = strap[FS_W];

  freq_select #(.FS_W(FS_W), .DIV3_MAP(DIV3_MAP)) u_sel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (released),
    .strap_fs_i (fs_q),
    .ctl_i      (ctl_i),
    .code_o     (freq_code_o),
    .div3_o     (pci_div3_o),
    .ss_en_o    (ss_en_o),
    .ss_down_o  (ss_down_o)
  );

  out_gate u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tri_i       (ctl_i[0]),
    .mode_i      (mode_q),
    .en_cpu_i    (en_cpu_i),
    .en_pci_i    (en_pci_i),
    .en_sdram_i  (en_sdram_i),
    .en_periph_i (en_periph_i),
    .cpu_o       (cpu_gate_o),
    .sdram_o     (sdram_gate_o),
    .pci_o       (pci_gate_o),
    .fix_o       (fix_gate_o)
  );

  assign tristate_o    = ctl_i[0];
  assign straps_out_o  = released;
  assign pin2_ref_o    = released & mode_q;
  assign pci_stop_in_o = released & ~mode_q;

  // strap bits read back inverted; reserved bits read as 1
  assign rb_cpu_o  = {~fs_q[2], en_cpu_i[6], 2'b11, en_cpu_i[3:0]};
  assign rb_pci_o  = {~fs_q[0], en_pci_i[6], 1'b1, en_pci_i[4:0]};
  assign rb_rsvd_o = {4'hF, ~fs_q[1], 1'b1, ~fs_q[3], 1'b1};

  a_r8_pin2_one_role: assert property (@(posedge clk_i) disable iff (!rst_ni)
    straps_out_o |-> $onehot({pin2_ref_o, pci_stop_in_o}));
  a_r6_readback_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (released && $past(released)) |-> ($stable(rb_rsvd_o) && $stable(rb_cpu_o[7])));
endmodule

// File: tb/clk_strap_ctl_tb.sv
module clk_strap_ctl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  fs_pad = '0;
  logic        mode_pad = 1'b0;
  logic [7:0]  ctl = '0, e_cpu = '0, e_pci = '0, e_sdr = '0, e_per = '0;
  logic        straps_out, pin2_ref, pci_stop_in, div3, ss_en, ss_down, tri_o;
  logic [3:0]  code, cpu_g, fix_g;
  logic [12:0] sdr_g;
  logic [5:0]  pci_g;
  logic [7:0]  rb_cpu, rb_pci, rb_rsvd;

  int nvec = 0, nbad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_strap_ctl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .fs_pad_i(fs_pad), .mode_pad_i(mode_pad),
    .ctl_i(ctl), .en_cpu_i(e_cpu), .en_pci_i(e_pci), .en_sdram_i(e_sdr),
    .en_periph_i(e_per), .straps_out_o(straps_out), .pin2_ref_o(pin2_ref),
    .pci_stop_in_o(pci_stop_in), .freq_code_o(code), .pci_div3_o(div3),
    .ss_en_o(ss_en), .ss_down_o(ss_down), .tristate_o(tri_o),
    .cpu_gate_o(cpu_g), .sdram_gate_o(sdr_g), .pci_gate_o(pci_g),
    .fix_gate_o(fix_g), .rb_cpu_o(rb_cpu), .rb_pci_o(rb_pci), .rb_rsvd_o(rb_rsvd)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got %0h want %0h", req, act, exp);
    end
  endtask

  // CPU and PCI rates in units of 10 kHz, indexed by code
  function automatic logic exp_div3(input logic [3:0] c);
    int cpu, pci, ratio10;
    case (c)
      4'd0:  begin cpu = 12400; pci = 4133; end
      4'd1:  begin cpu = 12000; pci = 4000; end
      4'd2:  begin cpu = 11499; pci = 3833; end
      4'd3:  begin cpu = 10999; pci = 3666; end
      4'd4:  begin cpu = 10500; pci = 3500; end
      4'd5:  begin cpu = 8330;  pci = 4165; end
      4'd6:  begin cpu = 8000;  pci = 4000; end
      4'd7:  begin cpu = 7500;  pci = 3750; end
      4'd8:  begin cpu = 10000; pci = 3333; end
      4'd9:  begin cpu = 9519;  pci = 3173; end
      4'd10: begin cpu = 8330;  pci = 2777; end
      4'd11: begin cpu = 9700;  pci = 3233; end
      4'd12: begin cpu = 9000;  pci = 3000; end
      4'd13: begin cpu = 7000;  pci = 3500; end
      4'd14: begin cpu = 6682;  pci = 3341; end
      default: begin cpu = 6000; pci = 3000; end
    endcase
    ratio10 = (cpu * 10 + pci / 2) / pci;
    return ratio10 > 25;
  endfunction

  task automatic check_gates(input string req, input logic m);
    logic t;
    t = ctl[0];
    check({req, " cpu"}, 32'(cpu_g), t ? 0 : 32'({e_cpu[6], e_cpu[2], e_cpu[1], e_cpu[0]}));
    check({req, " sdram"}, 32'(sdr_g), t ? 0 : 32'({e_cpu[3], e_sdr, e_per[7:4]}));
    check({req, " pci"}, 32'(pci_g), t ? 0 : 32'({e_pci[6], e_pci[4:0]}));
    check({req, " fix"}, 32'(fix_g), t ? 0 : 32'({e_per[3], e_per[2], e_per[1], e_per[0] & m}));
  endtask

  task automatic power_up(input logic [4:0] p);
    @(negedge clk);
    rst_ni = 1'b0; fs_pad = p[3:0]; mode_pad = p[4];
    repeat (2) @(negedge clk);
    #1;
    check("R1 outputs off in reset", 32'(straps_out), 0);
    check("R8 pin2 idle in reset", 32'({pin2_ref, pci_stop_in}), 0);
    @(negedge clk); rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    fs_pad = ~p[3:0]; mode_pad = ~p[4];
    repeat (2) @(negedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: got hang want finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    // R7: reserved and unused bits written 0
    e_cpu = 8'h4F; e_pci = 8'h5F; e_sdr = 8'hFF; e_per = 8'hFF; ctl = 8'h00;
    for (int p = 0; p < 32; p++) begin
      logic [4:0] s;
      s = 5'(p);
      power_up(s);
      check("R1 outputs on after release", 32'(straps_out), 1);
      check("R1 R2 strap code frozen", 32'(code), 32'(s[3:0]));
      check("R9 divide from strap", 32'(div3), 32'(exp_div3(s[3:0])));
      check("R6 rb_cpu", 32'(rb_cpu), 32'({~s[2], e_cpu[6], 2'b11, e_cpu[3:0]}));
      check("R6 R7 rb_pci", 32'(rb_pci), 32'({~s[0], e_pci[6], 1'b1, e_pci[4:0]}));
      check("R6 R7 rb_rsvd", 32'(rb_rsvd), 32'({4'hF, ~s[1], 1'b1, ~s[3], 1'b1}));
      check("R8 pin2 role", 32'({pin2_ref, pci_stop_in}), s[4] ? 32'd2 : 32'd1);
      check_gates("R8 R5 mode gating", s[4]);
    end

    // desktop mode, strap code 5, full control-byte sweep
    power_up(5'b1_0101);
    for (int c = 0; c < 256; c++) begin
      logic [7:0] b;
      logic [3:0] ec;
      b = 8'(c);
      @(negedge clk); ctl = b; #1;
      ec = b[3] ? {b[2], b[6:4]} : 4'b0101;
      check("R2 code source", 32'(code), 32'(ec));
      check("R9 divide code", 32'(div3), 32'(exp_div3(ec)));
      check("R3 spread enable", 32'(ss_en), 32'(b[1]));
      check("R3 spread kind", 32'(ss_down), 32'(b[1] & b[7]));
      check("R4 tristate", 32'(tri_o), 32'(b[0]));
      check_gates("R4 R5 gates vs ctl", 1'b1);
    end

    // walking zero across every enable bit
    @(negedge clk); ctl = 8'h00;
    for (int g = 0; g < 4; g++) begin
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        e_cpu = 8'hFF; e_pci = 8'hFF; e_sdr = 8'hFF; e_per = 8'hFF;
        case (g)
          0: e_cpu[k] = 1'b0;
          1: e_pci[k] = 1'b0;
          2: e_sdr[k] = 1'b0;
          default: e_per[k] = 1'b0;
        endcase
        #1;
        check_gates("R5 R7 walking zero", 1'b1);
        check("R7 rb_cpu reserved", 32'(rb_cpu[5:4]), 32'd3);
        check("R7 rb_pci reserved", 32'(rb_pci[5]), 32'd1);
        check("R6 rb_cpu echo", 32'(rb_cpu[6:0]), 32'({e_cpu[6], 2'b11, e_cpu[3:0]}));
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule